// File: doc/BRIEF.md
# Power-On Reset Sequencer with Configuration Straps

This block runs the start-up sequence of a processor core from a single active-low reset pin. While the pin is low it keeps the clock generator in bypass and the core in reset. When the pin is released it captures three configuration strap pins. Two of them become pin-multiplexing mode bits. The third selects the clock source.

The core is then held in reset for a countdown. If the clock-source strap chose the internal oscillator, a long oscillator-settling interval comes first. A fixed reset-propagation interval always follows. Only when the whole countdown has expired does the block sample a three-bit boot-mode bus into a register. In the next cycle it lets the core run.

The reset pin passes through a two-stage synchronizer, which clears at once and releases in step with the clock. Every other flop is cleared from the synchronized reset. A new reset at any point aborts the sequence, and the sequence then starts over from the beginning.

Top module: `por_strap_sequencer`

## Requirements
- R1: While the reset pin is low, and for the two reference-clock edges of synchronization after it rises, bypass_o is 1 and core_rst_n, mode_pmux_o, mode_smux_o, clk_mode_o and boot_mode_o are all 0.
- R2: At the third rising clock edge after the reset pin goes high, mode_pmux_o takes strap_pmux and mode_smux_o takes strap_smux. Later changes of those straps have no effect until the next reset.
- R3: At that same edge clk_mode_o takes strap_clksel (0 = internal oscillator with crystal, 1 = external clock pin), and bypass_o falls to 0. Later changes of strap_clksel have no effect until the next reset.
- R4: With strap_clksel = 0, the core is released OSC_CYCLES + PROP_CYCLES + 1 clock edges after the strap-capture edge.
- R5: With strap_clksel = 1, the core is released PROP_CYCLES + 1 clock edges after the strap-capture edge, with no oscillator interval.
- R6: boot_mode_o is loaded with boot_pins only at the edge that ends the countdown. Values on boot_pins before or after that edge have no effect.
- R7: core_rst_n rises at the same edge that writes boot_mode_o, so it reads 1 in the cycle after the boot-mode write. It then stays 1 until the next reset.
- R8: A reset during any part of the sequence clears every output to its R1 value at once. The full countdown is restarted on the next release.
- R9: Once the core runs, the mode bits, clock-mode bit and boot-mode register hold their values whatever the strap and boot pins do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_pin_n | input | 1 | External active-low reset pin |
| strap_pmux | input | 1 | Strap for the parallel/host-port mux mode |
| strap_smux | input | 1 | Strap for the serial-port-2 mux mode |
| strap_clksel | input | 1 | Clock-source strap: 0 internal oscillator, 1 external clock |
| boot_pins | input | 3 | Boot-mode pins |
| mode_pmux_o | output | 1 | Latched parallel/host-port mux mode bit |
| mode_smux_o | output | 1 | Latched serial-port-2 mux mode bit |
| clk_mode_o | output | 1 | Latched clock-source select |
| boot_mode_o | output | 3 | Boot-mode register |
| bypass_o | output | 1 | Clock generator held in bypass |
| core_rst_n | output | 1 | Active-low core reset (1 = core runs) |

## Verification
The sequence is started once with the oscillator strap and once with the external-clock strap. The measured cycles to release tell the two countdown lengths apart. While the countdown runs, the straps and boot pins are changed, which separates values latched at the correct edge from values taken early or late. One run is aborted partway through the oscillator interval. It must clear everything and then repeat the full count, which shows that the counter restarts and does not resume. Pins wiggled after release must leave all latched outputs unchanged.

// File: rtl/porseq_pkg.sv
package porseq_pkg;
    localparam int BOOT_W = 3;

    typedef enum logic [2:0] {
        RESET_HELD  = 3'd0,
        OSC_SETTLE  = 3'd1,
        PROPAGATE   = 3'd2,
        BOOT_SAMPLE = 3'd3,
        RUN         = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e          state;
        logic                pmux;
        logic                smux;
        logic                clkmode;
        logic [BOOT_W-1:0]   boot;
        logic                run_n;
    } seq_regs_t;
endpackage

// File: rtl/porseq_rst_sync.sv
module porseq_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/porseq_delay_cnt.sv
module porseq_delay_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/por_strap_sequencer.sv
module por_strap_sequencer
    import porseq_pkg::*;
#(
    parameter int OSC_CYCLES  = 41032,
    parameter int PROP_CYCLES = 70,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_ref,
    input  logic              rst_pin_n,
    input  logic              strap_pmux,
    input  logic              strap_smux,
    input  logic              strap_clksel,
    input  logic [BOOT_W-1:0] boot_pins,
    output logic              mode_pmux_o,
    output logic              mode_smux_o,
    output logic              clk_mode_o,
    output logic [BOOT_W-1:0] boot_mode_o,
    output logic              bypass_o,
    output logic              core_rst_n
);
    localparam int OSC_W  = $clog2(OSC_CYCLES + 1);
    localparam int PROP_W = $clog2(PROP_CYCLES + 1);
    localparam int MAX_W  = (OSC_W > PROP_W) ? OSC_W : PROP_W;
    localparam int CNT_W  = (MAX_W > 16) ? MAX_W : 16;
    localparam logic [CNT_W-1:0] OSC_LAST  = CNT_W'(OSC_CYCLES - 1);
    localparam logic [CNT_W-1:0] PROP_LAST = CNT_W'(PROP_CYCLES - 1);

    logic             rst_sync_n;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] cnt;
    seq_regs_t        r_d, r_q;

    porseq_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk_ref),
        .pin_n  (rst_pin_n),
        .sync_n (rst_sync_n)
    );

    porseq_delay_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk_ref),
        .rst_n (rst_sync_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    always_comb begin
        r_d     = r_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (r_q.state)
            RESET_HELD: begin
                r_d.pmux    = strap_pmux;
                r_d.smux    = strap_smux;
                r_d.clkmode = strap_clksel;
                r_d.state   = strap_clksel ? PROPAGATE : OSC_SETTLE;
                cnt_clr     = 1'b1;
            end
            OSC_SETTLE: begin
                if (cnt == OSC_LAST) begin
                    r_d.state = PROPAGATE;
                    cnt_clr   = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            PROPAGATE: begin
                if (cnt == PROP_LAST) begin
                    r_d.state = BOOT_SAMPLE;
                    cnt_clr   = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            BOOT_SAMPLE: begin
                r_d.boot  = boot_pins;
                r_d.run_n = 1'b1;
                r_d.state = RUN;
            end
            RUN: begin
                r_d = r_q;
            end
            default: begin
                r_d.state = RESET_HELD;
            end
        endcase
    end

    always_ff @(posedge clk_ref or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
            r_q.state   <= RESET_HELD;
            r_q.pmux    <= 1'b0;
            r_q.smux    <= 1'b0;
            r_q.clkmode <= 1'b0;
            r_q.boot    <= '0;
            r_q.run_n   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode_pmux_o = r_q.pmux;
    assign mode_smux_o = r_q.smux;
    assign clk_mode_o  = r_q.clkmode;
    assign boot_mode_o = r_q.boot;
    assign core_rst_n  = r_q.run_n;
    assign bypass_o    = (r_q.state == RESET_HELD);
endmodule

// File: rtl/porseq_checker.sv
module porseq_checker
    import porseq_pkg::*;
#(
    parameter int OSC_CYCLES  = 41032,
    parameter int PROP_CYCLES = 70,
    parameter int CNT_W       = 16
) (
    input logic              clk_ref,
    input logic              rst_sync_n,
    input logic [2:0]        state,
    input logic [CNT_W-1:0]  cnt,
    input logic              mode_pmux_o,
    input logic              mode_smux_o,
    input logic              clk_mode_o,
    input logic [BOOT_W-1:0] boot_mode_o,
    input logic              bypass_o,
    input logic              core_rst_n
);
    AST_HELD_QUIET: assert property (@(posedge clk_ref)
        !rst_sync_n |-> (bypass_o && !core_rst_n && !mode_pmux_o && !mode_smux_o
                         && !clk_mode_o && boot_mode_o == '0)); // R1

    AST_MODES_FROZEN: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
        !bypass_o |=> $stable({mode_pmux_o, mode_smux_o, clk_mode_o})); // R2

    AST_LEAVE_BYPASS_IN_RESET: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
        $fell(bypass_o) |-> !core_rst_n); // R3

    AST_OSC_ONLY_INTERNAL: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
        state == 3'(OSC_SETTLE) |-> !clk_mode_o); // R4

    AST_OSC_CNT_BOUND: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
        state == 3'(OSC_SETTLE) |-> cnt < CNT_W'(OSC_CYCLES)); // R4

    AST_PROP_CNT_BOUND: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
        state == 3'(PROPAGATE) |-> cnt < CNT_W'(PROP_CYCLES)); // R5

    AST_RELEASE_AFTER_SAMPLE: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
        $rose(core_rst_n) |-> $past(state) == 3'(BOOT_SAMPLE)); // R7

    AST_RELEASE_STICKS: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
        core_rst_n |=> core_rst_n); // R7

    AST_BOOT_FROZEN: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
        core_rst_n |=> $stable(boot_mode_o)); // R9
endmodule

bind por_strap_sequencer porseq_checker #(
    .OSC_CYCLES  (OSC_CYCLES),
    .PROP_CYCLES (PROP_CYCLES),
    .CNT_W       (CNT_W)
) u_chk (
    .clk_ref     (clk_ref),
    .rst_sync_n  (rst_sync_n),
    .state       (r_q.state),
    .cnt         (cnt),
    .mode_pmux_o (mode_pmux_o),
    .mode_smux_o (mode_smux_o),
    .clk_mode_o  (clk_mode_o),
    .boot_mode_o (boot_mode_o),
    .bypass_o    (bypass_o),
    .core_rst_n  (core_rst_n)
);

// File: tb/por_strap_sequencer_test.sv
module por_strap_sequencer_test;
    localparam int OSC  = 25;
    localparam int PROP = 7;

    logic       clk_ref = 1'b0;
    logic       rst_pin_n = 1'b0;
    logic       strap_pmux = 1'b0, strap_smux = 1'b0, strap_clksel = 1'b0;
    logic [2:0] boot_pins = 3'd0;
    logic       mode_pmux_o, mode_smux_o, clk_mode_o, bypass_o, core_rst_n;
    logic [2:0] boot_mode_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk_ref = ~clk_ref;

    por_strap_sequencer #(.OSC_CYCLES(OSC), .PROP_CYCLES(PROP)) uut (
        .clk_ref, .rst_pin_n, .strap_pmux, .strap_smux, .strap_clksel, .boot_pins,
        .mode_pmux_o, .mode_smux_o, .clk_mode_o, .boot_mode_o, .bypass_o, .core_rst_n
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on every clock
    int       m_sa = 0, m_sb = 0, m_el = 0, m_tot = 0;
    bit       m_arm = 0, m_pm = 0, m_sm = 0, m_ck = 0, m_run = 0;
    bit [2:0] m_boot = 0;

    always @(posedge clk_ref) begin
        if (!rst_pin_n) begin
            m_sa = 0; m_sb = 0; m_arm = 0; m_el = 0;
            m_pm = 0; m_sm = 0; m_ck = 0; m_run = 0; m_boot = 0;
        end else begin
            if (m_arm) begin
                m_el++;
                if (m_el == m_tot) begin
                    m_boot = boot_pins;
                    m_run  = 1;
                end
            end else if (m_sb != 0) begin
                m_arm = 1; m_el = 0;
                m_pm = strap_pmux; m_sm = strap_smux; m_ck = strap_clksel;
                m_tot = (strap_clksel ? 0 : OSC) + PROP + 1;
            end
            m_sb = m_sa;
            m_sa = 1;
        end
        #1;
        if (!finished) begin
            chk(core_rst_n == m_run, m_arm ? "R7" : "R1", core_rst_n, m_run);
            chk(bypass_o == !m_arm, m_arm ? "R3" : "R1", bypass_o, !m_arm);
            chk(mode_pmux_o == m_pm && mode_smux_o == m_sm, m_arm ? "R2" : "R1",
                {mode_pmux_o, mode_smux_o}, {m_pm, m_sm});
            chk(clk_mode_o == m_ck, m_arm ? "R3" : "R1", clk_mode_o, m_ck);
            chk(boot_mode_o == m_boot, m_arm ? "R6" : "R1", boot_mode_o, m_boot);
        end
    end

    // Raise reset pin and count edges until release
    task automatic run_seq(output int edges);
        @(negedge clk_ref) rst_pin_n = 1'b1;
        edges = 0;
        for (int i = 0; i < 1000; i++) begin
            @(posedge clk_ref); #2;
            edges++;
            if (core_rst_n) break;
        end
    endtask

    initial begin
        int e;
        logic [5:0] snap;
        // Reset held
        strap_pmux = 1; strap_smux = 0; strap_clksel = 0; boot_pins = 3'd5;
        repeat (5) @(negedge clk_ref);
        chk(bypass_o && !core_rst_n && !mode_pmux_o && !clk_mode_o && boot_mode_o == 0,
            "R1", {bypass_o, core_rst_n}, 2);

        // Oscillator strap; change straps and boot pins mid-count
        fork
            run_seq(e);
            begin
                repeat (10) @(negedge clk_ref);
                strap_pmux = 0; strap_smux = 1; strap_clksel = 1; boot_pins = 3'd2;
                repeat (OSC) @(negedge clk_ref);
                boot_pins = 3'd6;
            end
        join
        chk(e == OSC + PROP + 4, "R4", e, OSC + PROP + 4);
        chk(boot_mode_o == 3'd6, "R6", boot_mode_o, 6);
        chk(mode_pmux_o == 1 && mode_smux_o == 0, "R2", {mode_pmux_o, mode_smux_o}, 2);
        chk(clk_mode_o == 0, "R3", clk_mode_o, 0);

        // Frozen while running
        snap = {mode_pmux_o, mode_smux_o, clk_mode_o, boot_mode_o};
        for (int k = 0; k < 20; k++) begin
            @(negedge clk_ref);
            boot_pins = 3'(k); strap_pmux = k[0]; strap_smux = k[1]; strap_clksel = k[2];
        end
        @(negedge clk_ref);
        chk({mode_pmux_o, mode_smux_o, clk_mode_o, boot_mode_o} == snap && core_rst_n,
            "R9", {mode_pmux_o, mode_smux_o, clk_mode_o, boot_mode_o}, snap);

        // External clock strap
        @(negedge clk_ref) rst_pin_n = 1'b0;
        strap_pmux = 0; strap_smux = 1; strap_clksel = 1; boot_pins = 3'd3;
        #1;
        chk(!core_rst_n && bypass_o && boot_mode_o == 0, "R8", core_rst_n, 0);
        repeat (4) @(negedge clk_ref);
        run_seq(e);
        chk(e == PROP + 4, "R5", e, PROP + 4);
        chk(clk_mode_o == 1 && mode_smux_o == 1 && mode_pmux_o == 0, "R3",
            {mode_pmux_o, mode_smux_o, clk_mode_o}, 3);
        chk(boot_mode_o == 3'd3, "R6", boot_mode_o, 3);

        // Abort in the oscillator interval, then full restart
        @(negedge clk_ref) rst_pin_n = 1'b0;
        strap_clksel = 0; boot_pins = 3'd1;
        repeat (3) @(negedge clk_ref);
        rst_pin_n = 1'b1;
        repeat (12) @(negedge clk_ref);
        rst_pin_n = 1'b0;
        #1;
        chk(bypass_o && !core_rst_n && !mode_smux_o && !clk_mode_o, "R8",
            {bypass_o, core_rst_n}, 2);
        repeat (3) @(negedge clk_ref);
        run_seq(e);
        chk(e == OSC + PROP + 4, "R8", e, OSC + PROP + 4);
        chk(boot_mode_o == 3'd1, "R6", boot_mode_o, 1);

        repeat (3) @(negedge clk_ref);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        finished = 1'b1;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule